// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block is the transmit half of a UART-style serial port. A character is placed in a one-entry holding register. A shift sequencer then takes it and sends it on a single serial line as one frame: a low start bit, between 5 and 9 data bits, an optional parity bit, and a high stop period. The stop period can be 1, 1.5 or 2 bit times, and an optional guard gap can follow it. While the holding register is being drained, the next character can be written into it, so frames can run back to back with no gap.

The surrounding system supplies a bit-clock enable pulse, `bit_tick`. Every output change happens on a `bit_tick` clock edge, which stands for the falling edge of the serial clock. In asynchronous mode one bit lasts `OVERSAMPLE` ticks, 16 by default. In synchronous mode one bit lasts a single tick.

Three one-cycle strobes control the block: enable, graceful disable and soft reset. The frame format is taken from the configuration inputs at the moment a character leaves the holding register.

Top module: `ser_char_tx`

## Requirements
- R1: After reset, `txd`=1, `hold_ready`=1 and `tx_empty`=1, and the transmitter is disabled. A character written while disabled stays in the holding register and no frame starts. A `tx_enable` strobe lets it be sent.
- R2: A frame is a start bit (0), then the data bits, then the optional parity bit, then a stop level of 1, and the line idles at 1. With `bit_tick` high every cycle, each bit lasts `OVERSAMPLE` (16) cycles in asynchronous mode (`cfg_sync`=0) and 1 cycle in synchronous mode.
- R3: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent. When `cfg_nine`=1, 9 data bits are sent, whatever `cfg_len` holds.
- R4: `cfg_parity` selects the parity bit: 0 = even (the data bits plus parity hold an even number of ones), 1 = odd, 2 = always 0, 3 = always 1, 4 to 7 = no parity bit.
- R5: With `cfg_msb_first`=1 the highest selected data bit goes first. With 0 bit 0 goes first.
- R6: `cfg_stop` selects the stop length: 0 = 1 bit, 1 = 1.5 bits (24 ticks) in asynchronous mode and 2 bits in synchronous mode, 2 or 3 = 2 bits.
- R7: After the stop bits, the line stays at 1 for a further `cfg_guard` bit times before the next start bit. With guard 0, a waiting character starts right after the stop period.
- R8: `hold_ready`=1 when the holding register is empty. `tx_empty`=1 when the holding register is empty and no frame is in progress. A write while `hold_ready`=0 is ignored.
- R9: A `tx_disable` strobe during a transfer completes the current frame and the held one, including the guard gap. After that no new frame starts until the next `tx_enable`.
- R10: A `tx_soft_rst` strobe immediately drives `txd` to 1, ends the frame and empties the holding register, so `hold_ready`=1 and `tx_empty`=1. It wins over a write in the same cycle. The enable state and the configuration are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Serial bit-clock enable (falling-edge strobe) |
| tx_enable | input | 1 | Enable strobe |
| tx_disable | input | 1 | Graceful disable strobe |
| tx_soft_rst | input | 1 | Immediate soft-reset strobe |
| cfg_sync | input | 1 | 1 = synchronous timing (one tick per bit) |
| cfg_nine | input | 1 | 1 = nine data bits |
| cfg_len | input | 2 | Data length code, 5 to 8 bits |
| cfg_parity | input | 3 | Parity mode code |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_stop | input | 2 | Stop length code |
| cfg_guard | input | GUARD_W | Guard gap in bit times |
| hold_wr | input | 1 | Holding register write strobe |
| hold_data | input | 9 | Character to write |
| hold_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding register and shifter both idle |
| txd | output | 1 | Serial output line |

## Verification
Two events can land in the same clock cycle, and the bench provokes each one on purpose.

The first is a soft reset arriving in the same cycle as a holding-register write, while a frame is being shifted. The bench drives both strobes at one falling edge. It then expects the line high, both flags set and no frame for hundreds of cycles afterwards.

The second is a disable strobe arriving in the same cycle as a write of the next character. The bench measures the low and high run lengths on `txd`. These show that the held character is still sent, after the full stop plus guard gap, and that nothing starts after it.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
   localparam int DATA_W  = 9;               // widest character
   localparam int FRAME_W = DATA_W + 2;      // start + data + parity
   localparam int NBIT_W  = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } tx_state_t;

   localparam logic [2:0] PAR_EVEN  = 3'd0;
   localparam logic [2:0] PAR_ODD   = 3'd1;
   localparam logic [2:0] PAR_ZERO  = 3'd2;
   localparam logic [2:0] PAR_ONE   = 3'd3;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
   import ser_tx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (srst) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr && !full) begin
         full <= 1'b1;
         data <= wdata;
      end
   end

   AST_WR_WHILE_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !take && !srst) |=> (full && $stable(data))); // R8
   AST_SRST_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !full); // R10
endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
   import ser_tx_pkg::*;
(
   input  logic [DATA_W-1:0]  data,
   input  logic               nine,
   input  logic [1:0]         len,
   input  logic [2:0]         parity,
   input  logic               msb_first,
   output logic [FRAME_W-1:0] frame,
   output logic [NBIT_W-1:0]  nbits
);
   logic [3:0]        n_data;
   logic [DATA_W-1:0] ordered;
   logic              ones;
   logic              has_par;
   logic              par_bit;

   assign n_data  = nine ? 4'd9 : (4'd5 + {2'b00, len});
   assign has_par = (parity < 3'd4);

   always_comb begin
      ones    = 1'b0;
      ordered = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(n_data)) begin
            ones ^= data[i];
            ordered[i] = msb_first ? data[int'(n_data) - 1 - i] : data[i];
         end
      end
      case (parity)
         PAR_EVEN: par_bit = ones;
         PAR_ODD:  par_bit = ~ones;
         PAR_ZERO: par_bit = 1'b0;
         PAR_ONE:  par_bit = 1'b1;
         default:  par_bit = 1'b1;
      endcase
   end

   always_comb begin
      frame = '0;                      // bit 0 is the start bit (0)
      for (int i = 0; i < DATA_W; i++)
         if (i < int'(n_data)) frame[i + 1] = ordered[i];
      if (has_par) frame[n_data + 4'd1] = par_bit;
      nbits = NBIT_W'(n_data) + NBIT_W'(1) + NBIT_W'(has_par);
   end
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
   import ser_tx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int GUARD_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               srst,
   input  logic               enabled,
   input  logic               hold_full,
   input  logic [FRAME_W-1:0] frame,
   input  logic [NBIT_W-1:0]  nbits,
   input  logic               sync_mode,
   input  logic [1:0]         stop_sel,
   input  logic [GUARD_W-1:0] guard,
   output logic               take,
   output logic               idle,
   output logic               txd
);
   localparam int TAIL_MAX = 2 * OVERSAMPLE + ((1 << GUARD_W) - 1) * OVERSAMPLE;
   localparam int TW       = $clog2(TAIL_MAX + 1);
   localparam logic [TW-1:0] OS_T   = TW'(OVERSAMPLE);
   localparam logic [TW-1:0] OS_15T = TW'(OVERSAMPLE + OVERSAMPLE / 2);
   localparam logic [TW-1:0] OS_2T  = TW'(2 * OVERSAMPLE);

   tx_state_t          st;
   logic [TW-1:0]      tcnt;
   logic [NBIT_W-1:0]  left;
   logic [FRAME_W-1:0] sr;
   logic [TW-1:0]      bit_ticks, stop_ticks, tail_ticks;

   always_comb begin
      bit_ticks = sync_mode ? TW'(1) : OS_T;
      if (sync_mode)
         stop_ticks = (stop_sel == 2'd0) ? TW'(1) : TW'(2);
      else if (stop_sel == 2'd0)
         stop_ticks = OS_T;
      else if (stop_sel == 2'd1)
         stop_ticks = OS_15T;
      else
         stop_ticks = OS_2T;
      tail_ticks = stop_ticks + TW'(guard) * bit_ticks;
   end

   assign idle = (st == ST_IDLE);
   assign take = tick && enabled && hold_full &&
                 ((st == ST_IDLE) || ((st == ST_TAIL) && (tcnt == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         txd  <= 1'b1;
         tcnt <= '0;
         left <= '0;
         sr   <= '0;
      end else if (srst) begin
         st   <= ST_IDLE;
         txd  <= 1'b1;
         tcnt <= '0;
         left <= '0;
      end else if (take) begin
         st   <= ST_SHIFT;
         txd  <= frame[0];
         sr   <= {1'b0, frame[FRAME_W-1:1]};
         left <= nbits - NBIT_W'(1);
         tcnt <= bit_ticks - TW'(1);
      end else if (tick) begin
         case (st)
            ST_SHIFT: begin
               if (tcnt != '0) begin
                  tcnt <= tcnt - TW'(1);
               end else if (left != '0) begin
                  txd  <= sr[0];
                  sr   <= {1'b0, sr[FRAME_W-1:1]};
                  left <= left - NBIT_W'(1);
                  tcnt <= bit_ticks - TW'(1);
               end else begin
                  txd  <= 1'b1;
                  st   <= ST_TAIL;
                  tcnt <= tail_ticks - TW'(1);
               end
            end
            ST_TAIL: begin
               if (tcnt != '0) tcnt <= tcnt - TW'(1);
               else            st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> txd); // R2
   AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !srst) |=> !txd); // R2
   AST_OFF_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && st == ST_IDLE) |=> (st == ST_IDLE)); // R1
   AST_SRST_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (txd && st == ST_IDLE)); // R10
endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
   import ser_tx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int GUARD_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               tx_enable,
   input  logic               tx_disable,
   input  logic               tx_soft_rst,
   input  logic               cfg_sync,
   input  logic               cfg_nine,
   input  logic [1:0]         cfg_len,
   input  logic [2:0]         cfg_parity,
   input  logic               cfg_msb_first,
   input  logic [1:0]         cfg_stop,
   input  logic [GUARD_W-1:0] cfg_guard,
   input  logic               hold_wr,
   input  logic [8:0]         hold_data,
   output logic               hold_ready,
   output logic               tx_empty,
   output logic               txd
);
   generate
      if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be an even value of at least 2");
      end
      if (GUARD_W < 1 || GUARD_W > 12) begin : g_bad_guard
         $error("GUARD_W must lie in 1..12");
      end
   endgenerate

   logic               en_q, dis_pend;
   logic               hold_full, take, seq_idle;
   logic [DATA_W-1:0]  held;
   logic [FRAME_W-1:0] frame;
   logic [NBIT_W-1:0]  nbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         dis_pend <= 1'b0;
      end else if (tx_soft_rst) begin
         dis_pend <= 1'b0;
      end else if (tx_disable) begin
         dis_pend <= en_q;
      end else if (tx_enable) begin
         en_q     <= 1'b1;
         dis_pend <= 1'b0;
      end else if (dis_pend && seq_idle && !hold_full) begin
         en_q     <= 1'b0;
         dis_pend <= 1'b0;
      end
   end

   ser_tx_hold u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (tx_soft_rst),
      .wr    (hold_wr),
      .wdata (hold_data),
      .take  (take),
      .full  (hold_full),
      .data  (held)
   );

   ser_tx_frame u_frame (
      .data      (held),
      .nine      (cfg_nine),
      .len       (cfg_len),
      .parity    (cfg_parity),
      .msb_first (cfg_msb_first),
      .frame     (frame),
      .nbits     (nbits)
   );

   ser_tx_seq #(.OVERSAMPLE(OVERSAMPLE), .GUARD_W(GUARD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bit_tick),
      .srst      (tx_soft_rst),
      .enabled   (en_q),
      .hold_full (hold_full),
      .frame     (frame),
      .nbits     (nbits),
      .sync_mode (cfg_sync),
      .stop_sel  (cfg_stop),
      .guard     (cfg_guard),
      .take      (take),
      .idle      (seq_idle),
      .txd       (txd)
   );

   assign hold_ready = !hold_full;
   assign tx_empty   = !hold_full && seq_idle;

   AST_OFF_ONLY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q) |-> $past(seq_idle && !hold_full)); // R9
endmodule

// File: tb/sim_ser_char_tx.sv
`timescale 1ns/100ps
module sim_ser_char_tx;
   typedef struct packed {
      logic        nine;
      logic [1:0]  len;
      logic [2:0]  par;
      logic        msb;
      logic [8:0]  data;
      logic [10:0] frame;   // bit i = i-th bit on the line
      logic [3:0]  n;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd3, 3'd4, 1'b0, 9'h055, 11'h0AA, 4'd9},   // R3 8 bits, no parity
      '{1'b0, 2'd3, 3'd0, 1'b0, 9'h001, 11'h202, 4'd10},  // R4 even
      '{1'b0, 2'd3, 3'd1, 1'b0, 9'h003, 11'h206, 4'd10},  // R4 odd
      '{1'b0, 2'd0, 3'd3, 1'b1, 9'h1F3, 11'h072, 4'd7},   // R3 R5 5 bits, mark, msb
      '{1'b0, 2'd2, 3'd2, 1'b0, 9'h0FF, 11'h0FE, 4'd9},   // R3 7 bits, space
      '{1'b1, 2'd0, 3'd4, 1'b1, 9'h100, 11'h002, 4'd10},  // R3 R5 nine overrides
      '{1'b0, 2'd1, 3'd0, 1'b0, 9'h02A, 11'h0D4, 4'd8},   // R3 R4 6 bits even
      '{1'b1, 2'd3, 3'd1, 1'b0, 9'h1FF, 11'h3FE, 4'd11}   // R4 nine odd
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b1;
   logic tx_enable = 1'b0, tx_disable = 1'b0, tx_soft_rst = 1'b0;
   logic cfg_sync = 1'b0, cfg_nine = 1'b0, cfg_msb_first = 1'b0;
   logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
   logic [2:0] cfg_parity = 3'd4;
   logic [7:0] cfg_guard = 8'd0;
   logic hold_wr = 1'b0;
   logic [8:0] hold_data = '0;
   logic hold_ready, tx_empty, txd;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ser_char_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .tx_enable(tx_enable), .tx_disable(tx_disable), .tx_soft_rst(tx_soft_rst),
      .cfg_sync(cfg_sync), .cfg_nine(cfg_nine), .cfg_len(cfg_len),
      .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first),
      .cfg_stop(cfg_stop), .cfg_guard(cfg_guard),
      .hold_wr(hold_wr), .hold_data(hold_data),
      .hold_ready(hold_ready), .tx_empty(tx_empty), .txd(txd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic write_char(input logic [8:0] d);
      @(negedge clk);
      hold_data = d; hold_wr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0;
   endtask

   task automatic strobe_en();
      @(negedge clk); tx_enable = 1'b1;
      @(negedge clk); tx_enable = 1'b0;
   endtask

   task automatic wait_fall(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (txd == 1'b0) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_empty();
      for (int k = 0; k < 6000; k++) begin
         @(negedge clk);
         if (tx_empty && txd) break;
      end
   endtask

   task automatic count_level(input logic lvl, input int max, output int n);
      n = 0;
      while (txd == lvl && n < max) begin
         n++;
         @(negedge clk);
      end
   endtask

   // called at first low negedge; returns n bits plus one stop sample
   task automatic read_frame(input int nb, output logic [11:0] got);
      got = '0;
      repeat (8) @(negedge clk);
      for (int i = 0; i <= nb; i++) begin
         if (i != 0) repeat (16) @(negedge clk);
         got[i] = txd;
      end
   endtask

   task automatic measure(input logic sy, input logic [1:0] sp, input logic [7:0] g,
                          input int exp_lo, input int exp_hi, input string req);
      int lo, hi;
      bit ok;
      cfg_sync = sy; cfg_stop = sp; cfg_guard = g;
      cfg_nine = 1'b0; cfg_len = 2'd3; cfg_parity = 3'd4; cfg_msb_first = 1'b0;
      bit_tick = 1'b0;
      write_char(9'h000);
      bit_tick = 1'b1;
      wait_fall(ok);
      hold_data = 9'h000; hold_wr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0;
      count_level(1'b0, 5000, lo);
      lo = lo + 1;
      count_level(1'b1, 5000, hi);
      check(ok && lo == exp_lo, {req, " low run"}, lo, exp_lo);
      check(hi == exp_hi, {req, " high gap"}, hi, exp_hi);
      wait_empty();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] got;
      logic [11:0] expv;
      bit ok;
      int n, lo, hi;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(txd == 1'b1, "R1 txd idle", txd, 1);
      check(hold_ready == 1'b1, "R1 ready", hold_ready, 1);
      check(tx_empty == 1'b1, "R1 empty", tx_empty, 1);

      // R1 write while disabled stays held; R8 write while full ignored
      write_char(9'h0F0);
      count_level(1'b1, 200, n);
      check(n == 200, "R1 no frame while disabled", n, 200);
      check(hold_ready == 1'b0, "R8 ready low when held", hold_ready, 0);
      check(tx_empty == 1'b0, "R8 empty low when held", tx_empty, 0);
      write_char(9'h000);
      strobe_en();
      wait_fall(ok);
      read_frame(9, got);
      check(ok && got == 12'h3E0, "R8 held char kept (R1 enable)", got, 12'h3E0);
      wait_empty();
      count_level(1'b1, 300, n);
      check(n == 300, "R8 ignored write not sent", n, 300);

      // vector table: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         cfg_nine = VEC[v].nine; cfg_len = VEC[v].len; cfg_parity = VEC[v].par;
         cfg_msb_first = VEC[v].msb; cfg_stop = 2'd0; cfg_guard = 8'd0; cfg_sync = 1'b0;
         write_char(VEC[v].data);
         wait_fall(ok);
         read_frame(int'(VEC[v].n), got);
         expv = {1'b0, VEC[v].frame};
         expv[VEC[v].n] = 1'b1;   // stop level
         check(ok && got == expv, $sformatf("R2 R3 R4 R5 vector %0d", v), got, expv);
         wait_empty();
      end

      // R6 stop lengths and R7 guard gap
      measure(1'b0, 2'd0, 8'd0, 144, 16, "R6 async 1 stop");
      measure(1'b0, 2'd1, 8'd0, 144, 24, "R6 async 1.5 stop");
      measure(1'b0, 2'd2, 8'd0, 144, 32, "R6 async 2 stop");
      measure(1'b0, 2'd3, 8'd0, 144, 32, "R6 async code 3");
      measure(1'b1, 2'd1, 8'd0, 9, 2, "R6 sync 1.5 as 2");
      measure(1'b1, 2'd0, 8'd3, 9, 4, "R7 sync guard 3");
      measure(1'b0, 2'd0, 8'd2, 144, 48, "R7 async guard 2");

      // R9 graceful disable with same-cycle write of the next character
      cfg_sync = 1'b0; cfg_stop = 2'd0; cfg_guard = 8'd2;
      bit_tick = 1'b0;
      write_char(9'h000);
      bit_tick = 1'b1;
      wait_fall(ok);
      hold_data = 9'h000; hold_wr = 1'b1; tx_disable = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0; tx_disable = 1'b0;
      count_level(1'b0, 5000, lo);
      lo = lo + 1;
      count_level(1'b1, 5000, hi);
      check(ok && lo == 144, "R9 current frame completes", lo, 144);
      check(hi == 48, "R9 guard kept while draining", hi, 48);
      count_level(1'b0, 5000, lo);
      check(lo == 144, "R9 held frame still sent", lo, 144);
      wait_empty();
      repeat (10) @(negedge clk);
      write_char(9'h000);
      count_level(1'b1, 300, n);
      check(n == 300, "R9 no start after drain", n, 300);
      check(hold_ready == 1'b0, "R9 char waits while off", hold_ready, 0);
      strobe_en();
      wait_fall(ok);
      check(ok, "R9 re-enable sends waiting char", ok, 1);
      wait_empty();

      // R10 soft reset mid-frame with same-cycle write
      cfg_guard = 8'd0;
      bit_tick = 1'b0;
      write_char(9'h000);
      bit_tick = 1'b1;
      wait_fall(ok);
      hold_data = 9'h000; hold_wr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0;
      repeat (40) @(negedge clk);
      tx_soft_rst = 1'b1; hold_wr = 1'b1; hold_data = 9'h000;
      @(negedge clk);
      tx_soft_rst = 1'b0; hold_wr = 1'b0;
      check(txd == 1'b1, "R10 line high at once", txd, 1);
      check(hold_ready == 1'b1, "R10 hold cleared", hold_ready, 1);
      check(tx_empty == 1'b1, "R10 empty set", tx_empty, 1);
      count_level(1'b1, 300, n);
      check(n == 300, "R10 write in reset cycle dropped", n, 300);
      write_char(9'h000);
      wait_fall(ok);
      check(ok, "R10 enable state kept", ok, 1);
      wait_empty();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule